// File: doc/BRIEF.md
# Cell-Framed Module Stream Interface

This block wraps a packet-processing module that trades fixed-size cells on a 32-bit word bus. Every cell is fourteen consecutive words. A one-cycle start strobe rides on the first word, and no per-word valid travels with the data. The receive side catches each cell into a small on-chip store that holds a few whole cells. It tells the module logic when a cell has fully arrived. It also lowers a cell-granular room signal toward the upstream source as soon as it could not take one more whole cell.

The transmit side replays stored cells in arrival order. It starts a cell only when the downstream room signal is high, and it always finishes a cell it has started. If the upstream source restarts a cell early, the partial cell is thrown away and counted. The datapath is a plain pass-through from the receive port to the transmit port, so the framing and flow control can be checked end to end.

Top module: `cell_port`

## Requirements
- R1: While `rst_n` is low and right after it rises: `tx_soc` and `tx_valid` are 0, `cells_held` is 0, `abort_cnt` is 0 and `rx_room` is 1.
- R2: A cell is 14 words, and its first word is the one sampled with `rx_soc` high. A stored cell leaves on `tx_data` with the same words in the same order, with `tx_valid` high for 14 cycles in a row and `tx_soc` high only with the first word.
- R3: On the clock edge that samples the 14th word of a cell, `cells_held` rises by one (unless a cell is released on that edge) and `cell_done` is high for exactly the following cycle.
- R4: `rx_room` is 0 exactly when the held cells plus a cell still being received reach the store depth of 4 cells, and 1 otherwise.
- R5: A cell starts on the transmit side (`tx_soc` high) only if `tx_room` was high at the edge that started it. While `tx_room` stays low, nothing is sent.
- R6: Once a cell has started, all 14 words are sent on consecutive cycles even if `tx_room` falls partway through.
- R7: An `rx_soc` that arrives before the current cell has 14 words ends that cell: the partial cell is never sent, `abort_cnt` rises by exactly one, and the new strobe word starts a fresh cell.
- R8: Cells leave in the order in which they finished arriving.
- R9: A cell whose strobe arrives while 4 cells are already held is dropped entirely. The held cells, `cells_held` and `abort_cnt` are unaffected.
- R10: Words on `rx_data` with `rx_soc` low while no cell is in progress are ignored: no cell is stored and `cell_done` stays 0.
- R11: `abort_cnt` saturates at its maximum value (255 with the default 8-bit width) and does not wrap.
- R12: With an empty store and `tx_room` high, `tx_soc` appears 14 edges after the edge that sampled the input strobe. A held cell starts on the edge right after the previous cell's last word, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 32 | Incoming cell word |
| rx_soc | input | 1 | Start-of-cell strobe, high with the first word |
| rx_room | output | 1 | Room for one more whole cell (back toward the source) |
| tx_data | output | 32 | Outgoing cell word |
| tx_soc | output | 1 | Start-of-cell strobe on the first outgoing word |
| tx_valid | output | 1 | Outgoing word present |
| tx_room | input | 1 | Downstream room for a whole cell |
| cell_done | output | 1 | One-cycle pulse after a cell has been fully captured |
| cells_held | output | 3 | Number of complete cells in the store |
| abort_cnt | output | 8 | Saturating count of cells cut short by an early strobe |

## Verification
`rx_room`, `abort_cnt`, `cells_held` and `cell_done` all change on the edge that samples the relevant input word. The bench therefore drives each word at a falling edge, updates its model to the state the next edge will produce, and compares the ports at the following falling edge. The transmit start is due 14 edges after the input strobe is sampled. The bench records the cycle of every observed `tx_soc` and checks the first gap against 15 falling-edge counts from the strobe drive, and the gap between two back-to-back cells against 14. Room on the transmit side is driven at falling edges, so each observed start is checked against the room value that was present at the edge that caused it.

// File: rtl/cell_port_pkg.sv
package cell_port_pkg;

  // Free whole-cell slots once held cells and an in-progress cell are counted.
  function automatic int unsigned cp_free_slots(input int unsigned held,
                                                input logic busy,
                                                input int unsigned depth);
    int unsigned used;
    used = held + (busy ? 32'd1 : 32'd0);
    return (used >= depth) ? 32'd0 : depth - used;
  endfunction

  // Flat store address of word idx inside cell slot slot.
  function automatic int unsigned cp_word_addr(input int unsigned slot,
                                               input int unsigned idx,
                                               input int unsigned words);
    return slot * words + idx;
  endfunction

  // Ring pointer advance for a depth that need not be a power of two.
  function automatic int unsigned cp_wrap_inc(input int unsigned v,
                                              input int unsigned depth);
    return (v + 32'd1 >= depth) ? 32'd0 : v + 32'd1;
  endfunction

  // Saturating increment of a w-bit counter.
  function automatic int unsigned cp_sat_inc(input int unsigned v,
                                             input int unsigned w);
    int unsigned mx;
    mx = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= mx) ? mx : v + 32'd1;
  endfunction

endpackage

// File: rtl/cp_rx_framer.sv
module cp_rx_framer
  import cell_port_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  parameter int ERR_W      = 8,
  localparam int IDX_W     = $clog2(CELL_WORDS),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W    = $clog2(DEPTH * CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_soc,
  input  logic [CNT_W-1:0]  held,
  input  logic [SLOT_W-1:0] wr_slot,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              commit_evt,
  output logic              abort_evt,
  output logic              busy,
  output logic [ERR_W-1:0]  abort_cnt
);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ERR_W-1:0]  abort_q;
  logic              slot_ok;
  logic              last_word;
  logic [IDX_W-1:0]  wr_idx;

  // A new cell may claim a slot only if a whole slot is free in the store.
  assign slot_ok   = 32'(held) < DEPTH;
  assign last_word = !rx_soc && active_q && (idx_q == IDX_W'(CELL_WORDS - 1));
  assign wr_idx    = rx_soc ? '0 : idx_q;

  assign wr_en      = rx_soc ? slot_ok : active_q;
  assign wr_addr    = ADDR_W'(cp_word_addr(32'(wr_slot), 32'(wr_idx), CELL_WORDS));
  assign wr_data    = rx_data;
  assign commit_evt = last_word;
  assign abort_evt  = rx_soc && active_q;
  assign busy       = active_q;
  assign abort_cnt  = abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      abort_q  <= '0;
    end else begin
      if (rx_soc) begin
        active_q <= slot_ok;
        idx_q    <= IDX_W'(1);
      end else if (active_q) begin
        if (last_word) begin
          active_q <= 1'b0;
          idx_q    <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (abort_evt) begin
        abort_q <= ERR_W'(cp_sat_inc(32'(abort_q), ERR_W));
      end
    end
  end

endmodule

// File: rtl/cp_cell_store.sv
module cp_cell_store
  import cell_port_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  localparam int WORDS     = DEPTH * CELL_WORDS,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              commit_evt,
  input  logic              release_evt,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [CNT_W-1:0]  held
);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [SLOT_W-1:0] tail_q;
  logic [SLOT_W-1:0] head_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign wr_slot = tail_q;
  assign rd_slot = head_q;
  assign held    = cnt_q;

  // The slots form a ring: the receive side fills the tail, the transmit side
  // drains the head; a reset empties the ring without touching the words.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (commit_evt) begin
        tail_q <= SLOT_W'(cp_wrap_inc(32'(tail_q), DEPTH));
      end
      if (release_evt) begin
        head_q <= SLOT_W'(cp_wrap_inc(32'(head_q), DEPTH));
      end
      case ({commit_evt, release_evt})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/cp_tx_sender.sv
module cp_tx_sender
  import cell_port_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  localparam int IDX_W     = $clog2(CELL_WORDS),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W    = $clog2(DEPTH * CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  held,
  input  logic              tx_room,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              release_evt,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_soc,
  output logic              tx_valid
);

  logic              sending_q;
  logic [IDX_W-1:0]  tidx_q;
  logic [WORD_W-1:0] data_q;
  logic              soc_q;
  logic              valid_q;
  logic              start;
  logic [IDX_W-1:0]  rd_idx;

  // Room is consulted only at a cell boundary; a started cell runs to the end.
  assign start       = !sending_q && (held != '0) && tx_room;
  assign rd_idx      = start ? '0 : tidx_q;
  assign rd_addr     = ADDR_W'(cp_word_addr(32'(rd_slot), 32'(rd_idx), CELL_WORDS));
  assign release_evt = sending_q && (tidx_q == IDX_W'(CELL_WORDS - 1));

  assign tx_data  = data_q;
  assign tx_soc   = soc_q;
  assign tx_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      tidx_q    <= '0;
      data_q    <= '0;
      soc_q     <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      soc_q   <= start;
      valid_q <= start || sending_q;
      if (start || sending_q) begin
        data_q <= rd_data;
      end
      if (start) begin
        sending_q <= 1'b1;
        tidx_q    <= IDX_W'(1);
      end else if (release_evt) begin
        sending_q <= 1'b0;
        tidx_q    <= '0;
      end else if (sending_q) begin
        tidx_q <= tidx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cell_port.sv
module cell_port
  import cell_port_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  parameter int ERR_W      = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ADDR_W    = $clog2(DEPTH * CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_soc,
  output logic              rx_room,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_soc,
  output logic              tx_valid,
  input  logic              tx_room,
  output logic              cell_done,
  output logic [CNT_W-1:0]  cells_held,
  output logic [ERR_W-1:0]  abort_cnt
);

  // Named internal events, visible to the bound checker.
  logic              rx_busy;
  logic              commit_evt;
  logic              abort_evt;
  logic              release_evt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic [CNT_W-1:0]  held;
  logic              done_q;

  cp_rx_framer #(
    .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .DEPTH(DEPTH), .ERR_W(ERR_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_soc(rx_soc),
    .held(held), .wr_slot(wr_slot), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_evt(commit_evt), .abort_evt(abort_evt),
    .busy(rx_busy), .abort_cnt(abort_cnt)
  );

  cp_cell_store #(
    .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_evt(commit_evt), .release_evt(release_evt),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_slot(wr_slot),
    .rd_slot(rd_slot), .held(held)
  );

  cp_tx_sender #(
    .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .DEPTH(DEPTH)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .held(held), .tx_room(tx_room),
    .rd_slot(rd_slot), .rd_data(rd_data), .rd_addr(rd_addr),
    .release_evt(release_evt), .tx_data(tx_data), .tx_soc(tx_soc),
    .tx_valid(tx_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= commit_evt;
    end
  end

  assign cell_done  = done_q;
  assign cells_held = held;
  assign rx_room    = cp_free_slots(32'(held), rx_busy, DEPTH) != 32'd0;

endmodule

// File: rtl/cell_port_chk.sv
module cell_port_chk #(
  parameter int CELL_WORDS = 14,
  parameter int DEPTH      = 4,
  parameter int ERR_W      = 8,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_room,
  input logic             tx_room,
  input logic             tx_soc,
  input logic             tx_valid,
  input logic             cell_done,
  input logic [CNT_W-1:0] cells_held,
  input logic [ERR_W-1:0] abort_cnt,
  input logic             rx_busy,
  input logic             commit_evt,
  input logic             release_evt
);

  // Length of the current outgoing run of valid words.
  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (tx_soc) begin
      run_q <= 1;
    end else if (tx_valid) begin
      run_q <= run_q + 1;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> cell_done);

  p_held_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !release_evt) |=> (32'(cells_held) == 32'($past(cells_held)) + 1));

  p_room_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(cells_held) + (rx_busy ? 32'd1 : 32'd0)) >= DEPTH) |-> !rx_room);

  p_start_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> $past(tx_room));

  p_full_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> (run_q == CELL_WORDS));

  p_abort_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_cnt != $past(abort_cnt)) |-> (32'(abort_cnt) == 32'($past(abort_cnt)) + 1));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cells_held) <= DEPTH);

endmodule

bind cell_port cell_port_chk #(
  .CELL_WORDS(CELL_WORDS), .DEPTH(DEPTH), .ERR_W(ERR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_room(rx_room), .tx_room(tx_room),
  .tx_soc(tx_soc), .tx_valid(tx_valid), .cell_done(cell_done),
  .cells_held(cells_held), .abort_cnt(abort_cnt), .rx_busy(rx_busy),
  .commit_evt(commit_evt), .release_evt(release_evt)
);

// File: tb/cell_port_bench.sv
module cell_port_bench;

  localparam int CELL    = 14;
  localparam int DEPTH   = 4;
  localparam int ERR_MAX = 255;

  logic        clk;
  logic        rst_n;
  logic [31:0] rx_data;
  logic        rx_soc;
  logic        rx_room;
  logic [31:0] tx_data;
  logic        tx_soc;
  logic        tx_valid;
  logic        tx_room;
  logic        cell_done;
  logic [2:0]  cells_held;
  logic [7:0]  abort_cnt;

  cell_port u_cell_port (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_soc(rx_soc),
    .rx_room(rx_room), .tx_data(tx_data), .tx_soc(tx_soc),
    .tx_valid(tx_valid), .tx_room(tx_room), .cell_done(cell_done),
    .cells_held(cells_held), .abort_cnt(abort_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Bench model of the receive side.
  logic [31:0] exp_words[$];
  logic [31:0] cur[CELL];
  int          widx = 0;
  bit          mid = 0;
  int          abort_exp = 0;
  int          seq = 0;
  int          soc_drive_cyc = 0;

  // Transmit-side observation.
  int  room_mode = 1;      // 0 low, 1 high, 2 random, 3 drop once a cell starts
  bit  room_prev = 0;
  int  mon_idx = 0;
  int  soc_list[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tx_valid) begin
        chk(tx_soc == (mon_idx == 0), "R2 strobe on first word", tx_soc, mon_idx == 0);
        if (exp_words.size() == 0) begin
          chk(0, "R8 unexpected word", tx_data, 0);
        end else begin
          logic [31:0] w;
          w = exp_words.pop_front();
          chk(tx_data == w, "R8 word order/content", tx_data, w);
        end
        mon_idx = (mon_idx == CELL - 1) ? 0 : mon_idx + 1;
      end else if (mon_idx != 0) begin
        chk(0, "R6 gap inside cell", mon_idx, CELL);
        mon_idx = 0;
      end
      if (tx_soc) begin
        chk(room_prev, "R5 start with room", room_prev, 1);
        soc_list.push_back(cyc);
      end
      case (room_mode)
        0:       room_prev = 1'b0;
        1:       room_prev = 1'b1;
        2:       room_prev = ($urandom_range(0, 3) != 0);
        default: room_prev = !tx_valid;
      endcase
      tx_room = room_prev;
    end
  end

  task automatic drive_word(input logic [31:0] d, input logic s);
    @(negedge clk);
    chk(rx_room == ((int'(cells_held) + (mid ? 1 : 0)) < DEPTH), "R4 room",
        rx_room, (int'(cells_held) + (mid ? 1 : 0)) < DEPTH);
    chk(int'(abort_cnt) == abort_exp, "R7 abort count", abort_cnt, abort_exp);
    rx_data = d;
    rx_soc  = s;
    if (s) begin
      soc_drive_cyc = cyc;
      if (mid) abort_exp = (abort_exp >= ERR_MAX) ? ERR_MAX : abort_exp + 1;
      mid    = (int'(cells_held) < DEPTH);
      cur[0] = d;
      widx   = 1;
    end else if (mid) begin
      cur[widx] = d;
      widx++;
      if (widx == CELL) begin
        for (int i = 0; i < CELL; i++) exp_words.push_back(cur[i]);
        mid = 0;
      end
    end
  endtask

  task automatic tick_idle();
    drive_word($urandom(), 1'b0);
  endtask

  task automatic send_cell(input int n);
    for (int i = 0; i < n; i++) begin
      drive_word((i == 0) ? {8'hA5, 24'(seq)} : $urandom(), i == 0);
    end
    seq++;
  endtask

  task automatic wait_room();
    while (!rx_room) tick_idle();
  endtask

  task automatic drain();
    room_mode = 1;
    for (int i = 0; i < 3000 && (exp_words.size() != 0 || tx_valid); i++) tick_idle();
    tick_idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; rx_data = '0; rx_soc = 0; tx_room = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!tx_soc && !tx_valid, "R1 strobes in reset", {tx_soc, tx_valid}, 0);
    chk(cells_held == 0 && abort_cnt == 0, "R1 counts in reset", {cells_held, abort_cnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rx_room == 1, "R1 room after reset", rx_room, 1);
    chk(!tx_valid && cells_held == 0, "R1 idle after reset", {tx_valid, cells_held}, 0);

    // R12 latency and back-to-back
    soc_list.delete();
    room_mode = 1;
    send_cell(CELL);
    begin
      int t0;
      t0 = soc_drive_cyc;
      send_cell(CELL);
      drain();
      chk(soc_list.size() == 2, "R12 two starts", soc_list.size(), 2);
      if (soc_list.size() == 2) begin
        chk(soc_list[0] - t0 == 15, "R12 first latency", soc_list[0] - t0, 15);
        chk(soc_list[1] - soc_list[0] == 14, "R12 back to back", soc_list[1] - soc_list[0], 14);
      end
    end

    // R3 / R4 / R9 / R5: fill with downstream closed
    room_mode = 0;
    tick_idle();
    soc_list.delete();
    send_cell(CELL);
    tick_idle();
    chk(cell_done == 1, "R3 done pulse", cell_done, 1);
    chk(cells_held == 1, "R3 held after capture", cells_held, 1);
    tick_idle();
    chk(cell_done == 0, "R3 pulse one cycle", cell_done, 0);
    for (int k = 0; k < 3; k++) begin wait_room(); send_cell(CELL); end
    tick_idle();
    chk(cells_held == DEPTH, "R9 store full", cells_held, DEPTH);
    chk(rx_room == 0, "R4 room low when full", rx_room, 0);
    send_cell(CELL);           // ignores room: must be dropped
    tick_idle();
    chk(cells_held == DEPTH, "R9 held unchanged", cells_held, DEPTH);
    chk(int'(abort_cnt) == abort_exp, "R9 abort unchanged", abort_cnt, abort_exp);
    repeat (10) tick_idle();
    chk(!tx_valid && soc_list.size() == 0, "R5 nothing sent without room",
        soc_list.size(), 0);
    drain();
    chk(exp_words.size() == 0 && cells_held == 0, "R8 four cells drained",
        exp_words.size(), 0);

    // R10: loose words while idle
    room_mode = 0;
    begin
      bit saw_done;
      saw_done = 0;
      for (int i = 0; i < 20; i++) begin tick_idle(); if (cell_done) saw_done = 1; end
      chk(!saw_done && cells_held == 0, "R10 loose words ignored", {saw_done, cells_held}, 0);
    end

    // R6: room falls once a cell starts
    send_cell(CELL);
    send_cell(CELL);
    room_mode = 3;
    for (int i = 0; i < 60; i++) tick_idle();
    chk(exp_words.size() == 0, "R6 both cells completed", exp_words.size(), 0);

    // R7: early strobe
    room_mode = 0;
    tick_idle();
    send_cell(5);
    send_cell(CELL);
    tick_idle();
    chk(abort_cnt == 1, "R7 one abort", abort_cnt, 1);
    chk(cells_held == 1, "R7 only new cell kept", cells_held, 1);
    drain();

    // R11: saturation by back-to-back strobes
    room_mode = 1;
    for (int i = 0; i < 300; i++) drive_word($urandom(), 1'b1);
    for (int i = 1; i < CELL; i++) drive_word($urandom(), 1'b0);
    tick_idle();
    chk(int'(abort_cnt) == ERR_MAX, "R11 saturated", abort_cnt, ERR_MAX);
    drain();

    // Random traffic with random downstream room
    room_mode = 2;
    for (int k = 0; k < 80; k++) begin
      repeat ($urandom_range(0, 3)) tick_idle();
      wait_room();
      if ($urandom_range(0, 7) == 0) send_cell($urandom_range(2, 13));
      else send_cell(CELL);
    end
    drain();
    chk(exp_words.size() == 0, "R8 all random cells delivered", exp_words.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule